// File: doc/BRIEF.md
# UART interrupt status and mask unit

This block sits beside the FIFOs of a UART and turns their fill levels and the receiver's error events into one level-sensitive interrupt. Every cycle it derives a set of live flags from the receive and transmit occupancy counts and from two programmable trigger levels. Those flags, together with single-cycle event pulses for receive overrun, framing error, parity error, receive timeout, modem status change and transmit overrun, are collected into a sticky status register. Software can clear the sticky status only by writing ones to it.

An interrupt mask decides which sticky bits may raise the interrupt. Software never writes the mask directly. One register address adds bits to it, another removes bits from it, and a write to the mask address itself is dropped. A simple register bus with select, write strobe, byte address, write data and combinational read data reaches all of these registers.

The FIFO storage, the serial shift logic and the baud timing live in neighbouring blocks.

Top module: `uart_irq_unit`

## Requirements
- R1: Live status (read at 0x2C) is rebuilt from the counts at every clock edge and appears one edge after the counts. bit0 = RX count >= RX trigger, bit1 = RX count is 0, bit2 = RX count equals RX depth (64), bit3 = TX count is 0, bit4 = TX count equals TX depth (64), bit13 = TX count >= TX trigger. All other bits read 0.
- R2: Each of live bits 4:0 that is set sets the same bit of the sticky status (read at 0x14) at the following edge.
- R3: Live bit13 (TX trigger reached) sets sticky bit10 at the following edge. Sticky bit11 is never set.
- R4: An event pulse sets its sticky bit one edge later: RX overrun bit5, framing error bit6, parity error bit7, receive timeout bit8, modem status bit9, TX overrun bit12.
- R5: A sticky bit stays set until a write to 0x14 has a 1 in that bit position. Bits written as 0 are left unchanged.
- R6: When a set source (a live flag or an event) and a software clear hit the same sticky bit in one cycle, the bit ends up set.
- R7: A write to 0x08 ORs the written bits into the mask, restricted to the implemented bits 0x17FF. A write to 0x0C clears the written bits from the mask. A write to 0x10 has no effect. The mask reads back at 0x10, and reads of 0x08 and 0x0C return 0.
- R8: The irq output is high exactly when some bit is set in both the mask and the sticky status. It follows those registers within the same cycle.
- R9: The RX trigger (0x20) and TX trigger (0x44) levels are 7-bit registers that reset to 32, take the low 7 bits of a write, and read back zero-extended.
- R10: While reset is asserted, the mask, sticky status and live status read 0 and irq is low. Reset is released on the second clock edge after rst_n rises.
- R11: Reads of unmapped addresses return 0. Writes to the live status address or to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 7 | Receive FIFO occupancy |
| tx_count | input | 7 | Transmit FIFO occupancy |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overrun | input | 1 | Transmit overrun pulse |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (read when low) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Each result has a fixed delay from its stimulus:
- Count changes reach the live status after one edge and the sticky status after two edges.
- Event pulses and register writes take effect after one edge.
- Read data and irq are combinational from the registers.

The bench changes inputs on a falling edge and samples on a later falling edge placed after exactly the required number of rising edges. In the count sweep, every sticky check follows a clear-all write issued one cycle after the counts change. That makes the sticky value exactly the image of the live flags, and the same sweep also covers the set-beats-clear rule.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int LIVE_W   = 14;
  localparam int STICKY_W = 13;
  localparam int NUM_EV   = 6;

  localparam int L_RX_TRIG  = 0;
  localparam int L_RX_EMPTY = 1;
  localparam int L_RX_FULL  = 2;
  localparam int L_TX_EMPTY = 3;
  localparam int L_TX_FULL  = 4;
  localparam int L_TX_TRIG  = 13;
  localparam int S_TX_TRIG  = 10;
  localparam int N_MIRROR   = 5;

  localparam logic [STICKY_W-1:0] STICKY_IMPL = 13'h17FF;

  localparam logic [7:0] OFS_ENABLE  = 8'h08;
  localparam logic [7:0] OFS_DISABLE = 8'h0C;
  localparam logic [7:0] OFS_MASK    = 8'h10;
  localparam logic [7:0] OFS_STICKY  = 8'h14;
  localparam logic [7:0] OFS_RX_TRIG = 8'h20;
  localparam logic [7:0] OFS_LIVE    = 8'h2C;
  localparam logic [7:0] OFS_TX_TRIG = 8'h44;

  // event index: 0 rx overrun, 1 framing, 2 parity, 3 timeout, 4 modem, 5 tx overrun
  function automatic int ev_pos(input int idx);
    case (idx)
      0: return 5;
      1: return 6;
      2: return 7;
      3: return 8;
      4: return 9;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_live.sv
module uart_irq_live
  import uart_irq_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_trig,
  input  logic [CNT_W-1:0]  tx_trig,
  output logic [LIVE_W-1:0] live_q
);
  localparam logic [CNT_W-1:0] RX_FULL_CNT = CNT_W'(RX_DEPTH);
  localparam logic [CNT_W-1:0] TX_FULL_CNT = CNT_W'(TX_DEPTH);

  logic [LIVE_W-1:0] live_d;

  always_comb begin
    live_d             = '0;
    live_d[L_RX_TRIG]  = (rx_count >= rx_trig);
    live_d[L_RX_EMPTY] = (rx_count == '0);
    live_d[L_RX_FULL]  = (rx_count == RX_FULL_CNT);
    live_d[L_TX_EMPTY] = (tx_count == '0);
    live_d[L_TX_FULL]  = (tx_count == TX_FULL_CNT);
    live_d[L_TX_TRIG]  = (tx_count >= tx_trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_d;
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky
  import uart_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LIVE_W-1:0]   live_q,
  input  logic [NUM_EV-1:0]   ev,
  input  logic [STICKY_W-1:0] clr_bits,
  output logic [STICKY_W-1:0] sticky_q
);
  logic [STICKY_W-1:0] set_vec;
  logic [STICKY_W-1:0] sticky_d;
  logic                sticky_en;
  logic                unused_live;

  assign unused_live = ^live_q[L_TX_TRIG-1:N_MIRROR];

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N_MIRROR; i++) set_vec[i] = live_q[i];
    set_vec[S_TX_TRIG] = live_q[L_TX_TRIG];
    for (int i = 0; i < NUM_EV; i++) set_vec[ev_pos(i)] = ev[i];
  end

  always_comb begin
    sticky_en = (|clr_bits) | (|(set_vec & ~sticky_q));
    sticky_d  = ((sticky_q & ~clr_bits) | set_vec) & STICKY_IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= '0;
    else if (sticky_en) sticky_q <= sticky_d;
  end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TRIG_W   = 7,
  parameter int TRIG_RST = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [LIVE_W-1:0]   live_q,
  input  logic [STICKY_W-1:0] sticky_q,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [STICKY_W-1:0] mask_q,
  output logic [STICKY_W-1:0] clr_bits,
  output logic [TRIG_W-1:0]   rx_trig_q,
  output logic [TRIG_W-1:0]   tx_trig_q
);
  localparam int N_TRIG = 2;

  logic                     wr_go;
  logic                     hit_en, hit_dis, hit_sticky;
  logic                     mask_en;
  logic [STICKY_W-1:0]      mask_d;
  logic [N_TRIG*TRIG_W-1:0] trig_all;
  logic                     unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:STICKY_W];

  always_comb begin
    wr_go      = bus_sel & bus_wr;
    hit_en     = (bus_addr == ADDR_W'(OFS_ENABLE));
    hit_dis    = (bus_addr == ADDR_W'(OFS_DISABLE));
    hit_sticky = (bus_addr == ADDR_W'(OFS_STICKY));
  end

  always_comb begin
    mask_en = wr_go & (hit_en | hit_dis);
    mask_d  = mask_q;
    if (hit_en)       mask_d = mask_q | (bus_wdata[STICKY_W-1:0] & STICKY_IMPL);
    else if (hit_dis) mask_d = mask_q & ~bus_wdata[STICKY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign clr_bits = (wr_go & hit_sticky) ? bus_wdata[STICKY_W-1:0] : '0;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
    localparam logic [7:0] T_OFS = (g == 0) ? OFS_RX_TRIG : OFS_TX_TRIG;
    logic              t_en;
    logic [TRIG_W-1:0] t_d;
    logic [TRIG_W-1:0] t_q;

    always_comb begin
      t_en = wr_go & (bus_addr == ADDR_W'(T_OFS));
      t_d  = bus_wdata[TRIG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    t_q <= TRIG_W'(TRIG_RST);
      else if (t_en) t_q <= t_d;
    end

    assign trig_all[g*TRIG_W +: TRIG_W] = t_q;
  end

  assign rx_trig_q = trig_all[0 +: TRIG_W];
  assign tx_trig_q = trig_all[TRIG_W +: TRIG_W];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(OFS_MASK))         bus_rdata = DATA_W'(mask_q);
      else if (bus_addr == ADDR_W'(OFS_STICKY))  bus_rdata = DATA_W'(sticky_q);
      else if (bus_addr == ADDR_W'(OFS_LIVE))    bus_rdata = DATA_W'(live_q);
      else if (bus_addr == ADDR_W'(OFS_RX_TRIG)) bus_rdata = DATA_W'(rx_trig_q);
      else if (bus_addr == ADDR_W'(OFS_TX_TRIG)) bus_rdata = DATA_W'(tx_trig_q);
    end
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TRIG_RST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              ev_rx_overrun,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_rx_timeout,
  input  logic              ev_modem,
  input  logic              ev_tx_overrun,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int TRIG_W = CNT_W;

  logic [1:0]          rst_pipe;
  logic                rst_n_sync;
  logic [LIVE_W-1:0]   live_q;
  logic [STICKY_W-1:0] sticky_q;
  logic [STICKY_W-1:0] mask_q;
  logic [STICKY_W-1:0] clr_bits;
  logic [TRIG_W-1:0]   rx_trig_q;
  logic [TRIG_W-1:0]   tx_trig_q;
  logic [NUM_EV-1:0]   ev_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  assign ev_vec = {ev_tx_overrun, ev_modem, ev_rx_timeout,
                   ev_parity_err, ev_frame_err, ev_rx_overrun};

  uart_irq_live #(
    .CNT_W(CNT_W), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
  ) live_i (
    .clk(clk), .rst_n(rst_n_sync),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_trig(rx_trig_q), .tx_trig(tx_trig_q),
    .live_q(live_q)
  );

  uart_irq_sticky sticky_i (
    .clk(clk), .rst_n(rst_n_sync),
    .live_q(live_q), .ev(ev_vec), .clr_bits(clr_bits),
    .sticky_q(sticky_q)
  );

  uart_irq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_W(TRIG_W), .TRIG_RST(TRIG_RST)
  ) regs_i (
    .clk(clk), .rst_n(rst_n_sync),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .live_q(live_q), .sticky_q(sticky_q),
    .bus_rdata(bus_rdata), .mask_q(mask_q), .clr_bits(clr_bits),
    .rx_trig_q(rx_trig_q), .tx_trig_q(tx_trig_q)
  );

  assign irq = |(mask_q & sticky_q);
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CNT_W-1:0]    rx_count,
  input logic [LIVE_W-1:0]   live_q,
  input logic [STICKY_W-1:0] sticky_q,
  input logic [STICKY_W-1:0] mask_q,
  input logic [STICKY_W-1:0] clr_bits,
  input logic [NUM_EV-1:0]   ev,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                irq
);
  AST_LIVE_RX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (live_q[L_RX_EMPTY] == ($past(rx_count) == '0))); // R1

  AST_LIVE_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q[N_MIRROR-1:0] & $past(live_q[N_MIRROR-1:0])) == $past(live_q[N_MIRROR-1:0]))); // R2

  AST_TXTRIG_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[L_TX_TRIG] |=> sticky_q[S_TX_TRIG]); // R3

  AST_NO_BIT11: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_q[11]); // R3

  AST_RX_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |=> sticky_q[5]); // R4 R6

  AST_TX_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev[5] |=> sticky_q[12]); // R4 R6

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q & $past(sticky_q & ~clr_bits)) == $past(sticky_q & ~clr_bits))); // R5

  AST_MASK_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_MASK)) |=> $stable(mask_q)); // R7

  AST_IRQ_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q == '0 || mask_q == '0) |-> !irq); // R8
endmodule

bind uart_irq_unit uart_irq_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n_sync), .rx_count(rx_count), .live_q(live_q),
  .sticky_q(sticky_q), .mask_q(mask_q), .clr_bits(clr_bits), .ev(ev_vec),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .irq(irq)
);

// File: tb/uart_irq_unit_tb_top.sv
`timescale 1ns/1ps
module uart_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  rx_count, tx_count;
  logic        ev_rx_overrun, ev_frame_err, ev_parity_err, ev_rx_timeout, ev_modem, ev_tx_overrun;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  uart_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .ev_rx_overrun(ev_rx_overrun), .ev_frame_err(ev_frame_err),
    .ev_parity_err(ev_parity_err), .ev_rx_timeout(ev_rx_timeout),
    .ev_modem(ev_modem), .ev_tx_overrun(ev_tx_overrun),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [7:0] A_EN = 8'h08, A_DIS = 8'h0C, A_MASK = 8'h10, A_STK = 8'h14;
  localparam logic [7:0] A_RT = 8'h20, A_LIVE = 8'h2C, A_TT = 8'h44;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_ev(input int i, input logic v);
    case (i)
      0: ev_rx_overrun = v;
      1: ev_frame_err  = v;
      2: ev_parity_err = v;
      3: ev_rx_timeout = v;
      4: ev_modem      = v;
      default: ev_tx_overrun = v;
    endcase
  endtask

  function automatic int ev_bit(input int i);
    case (i)
      0: return 5;
      1: return 6;
      2: return 7;
      3: return 8;
      4: return 9;
      default: return 12;
    endcase
  endfunction

  function automatic logic [31:0] exp_live(input int rx, input int tx, input int rt, input int tt);
    logic [31:0] v;
    v = '0;
    v[0]  = (rx >= rt);
    v[1]  = (rx == 0);
    v[2]  = (rx == 64);
    v[3]  = (tx == 0);
    v[4]  = (tx == 64);
    v[13] = (tx >= tt);
    return v;
  endfunction

  function automatic logic [31:0] exp_sticky(input logic [31:0] lv);
    logic [31:0] v;
    v = '0;
    v[4:0] = lv[4:0];
    v[10]  = lv[13];
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int trig_set [4];
    trig_set = '{0, 17, 32, 64};
    rst_n = 1'b0; rx_count = '0; tx_count = '0;
    ev_rx_overrun = 0; ev_frame_err = 0; ev_parity_err = 0;
    ev_rx_timeout = 0; ev_modem = 0; ev_tx_overrun = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);

    // R10 reset state, R9 trigger reset values
    rd(A_MASK, r); chk("R10 mask in reset", r, 32'h0);
    rd(A_STK, r);  chk("R10 sticky in reset", r, 32'h0);
    rd(A_LIVE, r); chk("R10 live in reset", r, 32'h0);
    chk("R10 irq in reset", {31'b0, irq}, 32'h0);
    rd(A_RT, r);   chk("R9 rx trigger reset", r, 32'd32);
    rd(A_TT, r);   chk("R9 tx trigger reset", r, 32'd32);

    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 trigger write and readback
    wr(A_RT, 32'hFFFF_FF91); rd(A_RT, r); chk("R9 rx trigger low bits", r, 32'h11);
    wr(A_TT, 32'd5);         rd(A_TT, r); chk("R9 tx trigger write", r, 32'd5);

    // R1 R2 R3 R6: sweep counts across several trigger levels
    foreach (trig_set[k]) begin
      wr(A_RT, trig_set[k]);
      wr(A_TT, trig_set[k]);
      for (int c = 0; c <= 64; c++) begin
        @(negedge clk);
        rx_count = 7'(c); tx_count = 7'(64 - c);
        @(negedge clk);
        rd(A_LIVE, r);
        chk("R1 live flags", r, exp_live(c, 64 - c, trig_set[k], trig_set[k]));
        wr(A_STK, 32'h1FFF);
        rd(A_STK, r);
        chk("R2 R3 R6 sticky image of live", r,
            exp_sticky(exp_live(c, 64 - c, trig_set[k], trig_set[k])));
      end
    end

    // quiet point: no live flag set
    wr(A_RT, 32'd32); wr(A_TT, 32'd32);
    @(negedge clk); rx_count = 7'd5; tx_count = 7'd5;
    repeat (2) @(negedge clk);
    wr(A_STK, 32'h1FFF);
    rd(A_STK, r); chk("R2 quiet sticky", r, 32'h0);

    // R4 R5 events
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); set_ev(i, 1'b1);
      @(negedge clk); set_ev(i, 1'b0);
      rd(A_STK, r); chk("R4 event sets sticky", r, 32'h1 << ev_bit(i));
      repeat (4) @(negedge clk);
      wr(A_STK, ~(32'h1 << ev_bit(i)));
      rd(A_STK, r); chk("R5 hold across other clears", r, 32'h1 << ev_bit(i));
      wr(A_STK, 32'h1 << ev_bit(i));
      rd(A_STK, r); chk("R5 clear by one", r, 32'h0);
      // R6 event and clear together
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = A_STK; bus_wdata = 32'h1 << ev_bit(i);
      set_ev(i, 1'b1);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; set_ev(i, 1'b0);
      rd(A_STK, r); chk("R6 event beats clear", r, 32'h1 << ev_bit(i));
      wr(A_STK, 32'h1FFF);
    end

    // R7 mask handling
    wr(A_EN, 32'h0A5);  rd(A_MASK, r); chk("R7 enable sets", r, 32'h0A5);
    wr(A_EN, 32'h100);  rd(A_MASK, r); chk("R7 enable ors", r, 32'h1A5);
    wr(A_DIS, 32'h0A0); rd(A_MASK, r); chk("R7 disable clears", r, 32'h105);
    wr(A_MASK, 32'hFFF); rd(A_MASK, r); chk("R7 direct mask write ignored", r, 32'h105);
    rd(A_EN, r);  chk("R7 enable reads zero", r, 32'h0);
    rd(A_DIS, r); chk("R7 disable reads zero", r, 32'h0);
    wr(A_EN, 32'hFFFF_FFFF); rd(A_MASK, r); chk("R7 implemented bits only", r, 32'h17FF);
    wr(A_DIS, 32'hFFFF_FFFF); rd(A_MASK, r); chk("R7 disable all", r, 32'h0);

    // R8 interrupt level
    @(negedge clk); ev_parity_err = 1;
    @(negedge clk); ev_parity_err = 0;
    chk("R8 masked off", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h080);  chk("R8 enable raises irq", {31'b0, irq}, 32'h1);
    wr(A_DIS, 32'h080); chk("R8 disable drops irq", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h040);  chk("R8 other bit masked", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h080);  chk("R8 re-enable", {31'b0, irq}, 32'h1);
    wr(A_STK, 32'h080); chk("R8 clear drops irq", {31'b0, irq}, 32'h0);
    @(negedge clk); rx_count = 7'd0;
    repeat (2) @(negedge clk);
    chk("R8 live source masked", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h002);  chk("R8 rx empty irq", {31'b0, irq}, 32'h1);

    // R11 unmapped and live-address writes
    rd(8'h30, r); chk("R11 unmapped read", r, 32'h0);
    rd(8'h00, r); chk("R11 unmapped read low", r, 32'h0);
    wr(A_LIVE, 32'hFFFF_FFFF);
    rd(A_LIVE, r); chk("R11 live write ignored", r, exp_live(0, 5, 32, 32));
    wr(8'h04, 32'hFFFF_FFFF);
    rd(A_MASK, r); chk("R11 unmapped write mask", r, 32'h0C2);
    rd(A_RT, r);   chk("R11 unmapped write trig", r, 32'd32);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule